// File: doc/BRIEF.md
# Supply-Aware Reset Sequencer with Critical-Command Gate

This block decides when a module's local logic may leave reset, and when that module may pass safety-critical commands on. It watches three digital conditions: a supply-good flag from an external voltage supervisor, evidence that the local oscillator clock is really toggling, and an enable handed over by the module that powered up earlier in the chain. Activity on the local clock is judged from an independent, free-running reference clock. A stopped oscillator therefore still gets noticed, and reset can still be asserted while it is stopped.

Reset is asserted asynchronously whenever any release condition is lost. Release happens synchronously in the local clock domain, and only after three things: a start-up delay (counted in reference cycles) that covers the worst-case oscillator start, a clock proven alive, and a number of local-clock hold cycles that let synchronously reset logic settle. After a further settling delay the block raises its own command enable for the next module. A critical-command request reaches the execution circuit only while that enable and the upstream enable are both high. When the supply flag drops, reset, the command enable and the command strobe all fall in the same instant, without waiting for any clock.

Top module: `rst_cmd_sequencer`

## Requirements
- R1: While `supply_ok` is low, `loc_rst_n`, `cmd_en_out` and `cmd_fire` are all 0, whatever `cmd_req` and `upstream_en_in` do.
- R2: After `supply_ok` rises, `loc_rst_n` stays 0 for at least `STARTUP_CYC` reference-clock cycles.
- R3: `loc_rst_n` is never released while the local clock is stopped. The clock counts as dead when no edge of it has been seen for `DEAD_CYC` reference cycles. If the clock starts late, release follows once it runs.
- R4: If the local clock stops while the block is running, `loc_rst_n` and `cmd_en_out` fall within `DEAD_CYC`+8 reference cycles, with no further local clock edge needed.
- R5: With the supply good and the clock running, `loc_rst_n` rises once the start-up delay, two synchronizer stages and `HOLD_CYC` local cycles have passed.
- R6: A falling `supply_ok` forces `loc_rst_n`, `cmd_en_out` and `cmd_fire` to 0 at once, asynchronously.
- R7: `cmd_en_out` rises exactly `SETTLE_CYC` local rising edges after the edge at which `loc_rst_n` rose.
- R8: `cmd_fire` equals `cmd_req` AND `upstream_en_in` while `cmd_en_out` is 1, and is 0 whenever `cmd_en_out` is 0.
- R9: After a clock loss ends with the supply still good, the sequence resumes at the clock check, so the start-up delay is not paid again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock used for delays and clock supervision |
| loc_clk | input | 1 | Local oscillator clock of the module being reset |
| supply_ok | input | 1 | Supply-good flag from the external supervisor; low acts as the master reset |
| upstream_en_in | input | 1 | Command enable from the module that powered up earlier |
| cmd_req | input | 1 | Critical-command request, local clock domain |
| loc_rst_n | output | 1 | Active-low reset for the local logic, released synchronously to loc_clk |
| cmd_en_out | output | 1 | Command enable handed to the next module in the chain |
| cmd_fire | output | 1 | Gated critical-command strobe to the execution circuit |

## Verification
The bench builds the block with `STARTUP_CYC`=24, `DEAD_CYC`=6, `HOLD_CYC`=5 and `SETTLE_CYC`=4. These values are short enough that a power-up, a clock stall, a late-starting oscillator and a supply drop all fit in one short run. `DEAD_CYC`=6 reference cycles is long compared with the 10 ns local clock, so a running clock is never mistaken for a dead one. The gap between the 24-cycle start-up delay and the recovery bound of 16 local cycles lets the bench tell a resumed sequence from a full restart.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  typedef enum logic [1:0] {
    SEQ_WAIT_OSC = 2'd0,
    SEQ_PROBE    = 2'd1,
    SEQ_RUN      = 2'd2
  } seq_state_t;
endpackage

// File: rtl/rsq_clk_monitor.sv
module rsq_clk_monitor #(
  parameter int DEAD_CYC = 16
) (
  input  logic ref_clk,
  input  logic loc_clk,
  input  logic rst_n,
  output logic clk_alive
);
  localparam int CW = $clog2(DEAD_CYC + 1);

  logic          tog_q;
  logic [2:0]    sync_q;
  logic          edge_seen;
  logic [CW-1:0] gap_q, gap_n;
  logic          alive_q;

  // Divide-by-two toggle in the local domain; it stops when the clock stops.
  always_ff @(posedge loc_clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= ~tog_q;
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], tog_q};
  end

  assign edge_seen = sync_q[1] ^ sync_q[2];

  always_comb begin
    gap_n = gap_q;
    if (edge_seen)                   gap_n = '0;
    else if (gap_q != CW'(DEAD_CYC)) gap_n = gap_q + 1'b1;
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q   <= CW'(DEAD_CYC);
      alive_q <= 1'b0;
    end else begin
      gap_q   <= gap_n;
      alive_q <= (gap_n != CW'(DEAD_CYC));
    end
  end

  assign clk_alive = alive_q;

  a_r3_edge_marks_alive: assert property (@(posedge ref_clk) disable iff (!rst_n)
    edge_seen |=> clk_alive);
endmodule

// File: rtl/rsq_ref_seq.sv
module rsq_ref_seq
  import rsq_pkg::*;
#(
  parameter int STARTUP_CYC = 20000
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic clk_alive,
  output logic release_ok
);
  localparam int SW = $clog2(STARTUP_CYC + 1);

  seq_state_t    state_q, state_n;
  logic [SW-1:0] wait_q, wait_n;

  always_comb begin
    state_n = state_q;
    wait_n  = wait_q;
    unique case (state_q)
      SEQ_WAIT_OSC: begin
        if (wait_q == SW'(STARTUP_CYC - 1)) state_n = SEQ_PROBE;
        else                                wait_n  = wait_q + 1'b1;
      end
      SEQ_PROBE: if (clk_alive)  state_n = SEQ_RUN;
      SEQ_RUN:   if (!clk_alive) state_n = SEQ_PROBE;
      default:   state_n = SEQ_WAIT_OSC;
    endcase
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_WAIT_OSC;
      wait_q  <= '0;
    end else begin
      state_q <= state_n;
      wait_q  <= wait_n;
    end
  end

  assign release_ok = (state_q == SEQ_RUN);

  a_r3_release_needs_clock: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(release_ok) |-> $past(clk_alive));
  a_r2_release_after_delay: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(release_ok) |-> $past(wait_q) == SW'(STARTUP_CYC - 1));
endmodule

// File: rtl/rsq_loc_reset.sv
module rsq_loc_reset #(
  parameter int HOLD_CYC   = 16,
  parameter int SETTLE_CYC = 8
) (
  input  logic loc_clk,
  input  logic arst_n,
  output logic rst_out_n,
  output logic cmd_en
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam int EW = $clog2(SETTLE_CYC + 1);

  logic [1:0]    sync_q;
  logic [HW-1:0] hold_q, hold_n;
  logic [EW-1:0] settle_q, settle_n;
  logic          rst_q, rst_n_nxt;
  logic          en_q, en_n;

  always_comb begin
    hold_n    = hold_q;
    rst_n_nxt = rst_q;
    if (sync_q[1] && !rst_q) begin
      if (hold_q == HW'(HOLD_CYC - 1)) rst_n_nxt = 1'b1;
      else                             hold_n    = hold_q + 1'b1;
    end
  end

  always_comb begin
    settle_n = settle_q;
    en_n     = en_q;
    if (rst_q && !en_q) begin
      if (settle_q == EW'(SETTLE_CYC - 1)) en_n     = 1'b1;
      else                                 settle_n = settle_q + 1'b1;
    end
  end

  always_ff @(posedge loc_clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q   <= '0;
      hold_q   <= '0;
      rst_q    <= 1'b0;
      settle_q <= '0;
      en_q     <= 1'b0;
    end else begin
      sync_q   <= {sync_q[0], 1'b1};
      hold_q   <= hold_n;
      rst_q    <= rst_n_nxt;
      settle_q <= settle_n;
      en_q     <= en_n;
    end
  end

  assign rst_out_n = rst_q;
  assign cmd_en    = en_q;

  a_r5_release_after_sync: assert property (@(posedge loc_clk) disable iff (!arst_n)
    $rose(rst_q) |-> $past(sync_q[1]));
  a_r7_enable_after_release: assert property (@(posedge loc_clk) disable iff (!arst_n)
    $rose(en_q) |-> rst_q && $past(rst_q));
endmodule

// File: rtl/rst_cmd_sequencer.sv
module rst_cmd_sequencer #(
  parameter int STARTUP_CYC = 20000,
  parameter int DEAD_CYC    = 16,
  parameter int HOLD_CYC    = 16,
  parameter int SETTLE_CYC  = 8
) (
  input  logic ref_clk,
  input  logic loc_clk,
  input  logic supply_ok,
  input  logic upstream_en_in,
  input  logic cmd_req,
  output logic loc_rst_n,
  output logic cmd_en_out,
  output logic cmd_fire
);
  logic clk_alive;
  logic release_ok;
  logic loc_arst_n;

  rsq_clk_monitor #(.DEAD_CYC(DEAD_CYC)) u_mon (
    .ref_clk  (ref_clk),
    .loc_clk  (loc_clk),
    .rst_n    (supply_ok),
    .clk_alive(clk_alive)
  );

  rsq_ref_seq #(.STARTUP_CYC(STARTUP_CYC)) u_seq (
    .ref_clk   (ref_clk),
    .rst_n     (supply_ok),
    .clk_alive (clk_alive),
    .release_ok(release_ok)
  );

  // Any lost condition asserts the local reset without a clock.
  assign loc_arst_n = supply_ok & release_ok;

  rsq_loc_reset #(.HOLD_CYC(HOLD_CYC), .SETTLE_CYC(SETTLE_CYC)) u_loc (
    .loc_clk  (loc_clk),
    .arst_n   (loc_arst_n),
    .rst_out_n(loc_rst_n),
    .cmd_en   (cmd_en_out)
  );

  assign cmd_fire = cmd_req & upstream_en_in & cmd_en_out;

  a_r1_off_means_reset: assert property (@(posedge ref_clk)
    !supply_ok |-> !loc_rst_n && !cmd_en_out && !cmd_fire);
  a_r6_enable_implies_reset_free: assert property (@(posedge ref_clk) disable iff (!supply_ok)
    cmd_en_out |-> loc_rst_n);
endmodule

// File: tb/rst_cmd_sequencer_tb.sv
module rst_cmd_sequencer_tb;
  localparam int STARTUP = 24;
  localparam int DEAD    = 6;
  localparam int HOLD    = 5;
  localparam int SETTLE  = 4;

  logic ref_clk = 1'b0;
  logic osc     = 1'b0;
  logic run     = 1'b1;
  logic supply_ok, upstream_en_in, cmd_req;
  logic loc_rst_n, cmd_en_out, cmd_fire;
  logic loc_clk;
  int total = 0;
  int bad   = 0;

  always #4 ref_clk = ~ref_clk;
  always #5 osc = ~osc;
  assign loc_clk = osc & run;

  rst_cmd_sequencer #(.STARTUP_CYC(STARTUP), .DEAD_CYC(DEAD), .HOLD_CYC(HOLD),
                      .SETTLE_CYC(SETTLE)) u_dut (
    .ref_clk(ref_clk), .loc_clk(loc_clk), .supply_ok(supply_ok),
    .upstream_en_in(upstream_en_in), .cmd_req(cmd_req),
    .loc_rst_n(loc_rst_n), .cmd_en_out(cmd_en_out), .cmd_fire(cmd_fire));

  // {upstream_en_in, cmd_req, expected cmd_fire} while enabled (R8)
  localparam logic [2:0] VEC [8] = '{3'b000, 3'b010, 3'b100, 3'b111,
                                     3'b010, 3'b111, 3'b100, 3'b000};

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_rst_loc(input int limit, output int n);
    n = 0;
    while (loc_rst_n !== 1'b1 && n < limit) begin
      @(negedge loc_clk);
      n++;
    end
  endtask

  task automatic stop_clk();
    @(negedge osc); run = 1'b0;
  endtask

  task automatic start_clk();
    @(negedge osc); run = 1'b1;
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog: got hung expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    supply_ok = 1'b0; upstream_en_in = 1'b1; cmd_req = 1'b1;
    repeat (5) @(negedge ref_clk);
    chk("R1 rst", loc_rst_n, 1'b0);
    chk("R1 en", cmd_en_out, 1'b0);
    chk("R1 fire", cmd_fire, 1'b0);

    // Normal power-up
    supply_ok = 1'b1;
    repeat (STARTUP - 1) @(negedge ref_clk);
    chk("R2 held", loc_rst_n, 1'b0);
    chk("R8 fire before en", cmd_fire, 1'b0);
    cmd_req = 1'b0;
    wait_rst_loc(30, n);
    chk("R5 released", loc_rst_n, 1'b1);
    repeat (SETTLE - 1) @(negedge loc_clk);
    chk("R7 en not early", cmd_en_out, 1'b0);
    @(negedge loc_clk);
    chk("R7 en on time", cmd_en_out, 1'b1);

    foreach (VEC[i]) begin
      @(negedge loc_clk);
      upstream_en_in = VEC[i][2];
      cmd_req        = VEC[i][1];
      #1 chk("R8 table", cmd_fire, VEC[i][0]);
    end

    // Clock stall while running
    upstream_en_in = 1'b1; cmd_req = 1'b1;
    stop_clk();
    repeat (DEAD + 8) @(negedge ref_clk);
    chk("R4 rst on stall", loc_rst_n, 1'b0);
    chk("R4 en on stall", cmd_en_out, 1'b0);
    chk("R8 fire on stall", cmd_fire, 1'b0);
    cmd_req = 1'b0;

    // Recovery without paying the start-up delay again
    start_clk();
    wait_rst_loc(16, n);
    chk("R9 quick recovery", loc_rst_n, 1'b1);
    repeat (SETTLE) @(negedge loc_clk);
    chk("R9 en back", cmd_en_out, 1'b1);

    // Supply drop: immediate, asynchronous
    cmd_req = 1'b1;
    #1 chk("R8 fire running", cmd_fire, 1'b1);
    @(negedge ref_clk); #2;
    supply_ok = 1'b0;
    #1;
    chk("R6 rst", loc_rst_n, 1'b0);
    chk("R6 en", cmd_en_out, 1'b0);
    chk("R6 fire", cmd_fire, 1'b0);
    cmd_req = 1'b0;

    // Power-up with the oscillator not running
    stop_clk();
    @(negedge ref_clk);
    supply_ok = 1'b1;
    repeat (STARTUP + 20) @(negedge ref_clk);
    chk("R3 no clock", loc_rst_n, 1'b0);
    start_clk();
    wait_rst_loc(20, n);
    chk("R3 late clock", loc_rst_n, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule